// File: doc/BRIEF.md
# Bidirectional GPIO Port with Rising-Edge Capture

This block is a memory-mapped general purpose I/O port that sits on a simple 32-bit register bus (byte address, read strobe, write strobe, write data, combinational read data). Every pin has its own direction bit. An output pin drives the value held in the port's output latch. An input pin is brought into the clock domain through a two-flop synchroniser, and software reads its synchronised value.

The synchronised input stream also feeds a rising-edge detector. Every 0-to-1 transition sets a sticky bit in an edge-capture register. A per-bit enable mask selects which captured edges raise the level-sensitive interrupt output. Software clears all captured edges at once by writing any value to the capture register. An edge that lands in the same cycle as that write is kept.

The pin count is the parameter `WIDTH`, from 1 to 32. Bus bits above `WIDTH` read as zero.

Top module: `gpio_edge_port`

## Requirements
- R1: After a cycle with `rst_n` low, every pin is an input (`pin_oe` all zero), and the output latch, mask and capture registers are all zero, so `irq` is 0.
- R2: A write to byte offset 0x4 (direction) sets `pin_oe` to the written bits from the next cycle on. A bit value of 1 makes that pin an output. Reading offset 0x4 returns the direction bits.
- R3: A write to offset 0x0 (data) loads the output latch, which appears on `pin_o` from the next cycle. Reading offset 0x0 returns the latch value for output bits. For input bits it returns the pin value as it was two clock edges earlier (two-flop synchroniser).
- R4: A 0-to-1 transition on a `pin_i` bit sets that bit of the capture register (offset 0xC) three clock edges after the new pin value is first sampled. The bit stays set until it is cleared. A 1-to-0 transition sets nothing.
- R5: A write of any data to offset 0xC clears all capture bits at the next edge. A rising edge that reaches the capture stage at that same edge is still recorded.
- R6: A write to offset 0x8 sets the mask. `irq` is 1 exactly when some bit is set in both the mask and the capture register. A mask bit of 0 keeps its captured edge from raising `irq`.
- R7: Read data bits at or above `WIDTH` are always zero. Write data bits at or above `WIDTH` are ignored.
- R8: Reads have no side effect; in particular, reading offset 0xC leaves the capture register unchanged. While `bus_rd` is low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe; takes effect at the next clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| pin_i | input | WIDTH | Pad input values (asynchronous) |
| pin_o | output | WIDTH | Output latch driven to the pads |
| pin_oe | output | WIDTH | Per-pin output enable (1 = output) |
| irq | output | 1 | Level interrupt: any masked captured edge |

## Verification
The sensitive overlap is a clearing write to the capture register in the same cycle as a fresh rising edge reaching the capture stage. The bench provokes it directly: it raises a pin, then issues the clearing write exactly two cycles later, so that the detected edge and the clear share one clock edge. It then requires the new bit to survive while every older bit is gone, and `irq` must follow if that bit is masked in. The random phase also lands many clears on edges by chance. Each one is judged against a cycle-level model built from the requirements.

// File: rtl/gpio_pkg.sv
// Package: shared register-select encoding and bus constants for the GPIO port.
// Assumes a 32-bit data bus and word-aligned register offsets.
package gpio_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    // Register selected by byte address bits [3:2]
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchroniser for the asynchronous pad inputs.
// Assumes STAGES >= 2; each bit is treated on its own (no bus coherency).
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the pad values along the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_cap.sv
// Module: rising-edge detector with a sticky capture register.
// Assumes pin_s is already synchronous. A clear wipes the old bits but keeps
// any edge detected in the same cycle.
module gpio_edge_cap #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_s,
    input  logic             clr,
    output logic [WIDTH-1:0] cap_q,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev_q;

    // Detect 0-to-1 transitions against the previous sample
    assign rise = pin_s & ~prev_q;

    // Remember the previous sample and accumulate edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            cap_q  <= '0;
        end else begin
            prev_q <= pin_s;
            cap_q  <= (clr ? '0 : cap_q) | rise;
        end
    end

    // R4: without a clear no captured bit is lost
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

    // R4: a bit only appears where an edge was seen
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q & ~$past(cap_q) & ~$past(rise)) == '0));

    // R5: after a clear only same-cycle edges remain
    a_r5_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cap_q == $past(rise)));

endmodule

// File: rtl/gpio_regs.sv
// Module: data, direction and mask registers, write decode and read mux.
// Assumes the register select has already been taken from the address.
// Reads are combinational and have no side effects.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             wr,
    input  logic             rd,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin_s,
    input  logic [WIDTH-1:0] cap_q,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] mask_q,
    output logic             cap_clr,
    output logic [BUS_W-1:0] rdata
);

    logic [WIDTH-1:0] rd_word;

    // Software-writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_DATA: out_q  <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_MASK: mask_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Any write to the capture offset clears it
    assign cap_clr = wr && (sel == SEL_CAP);

    // Select the read word, zero-extended to the bus
    always_comb begin
        rd_word = '0;
        rdata   = '0;
        if (rd) begin
            case (sel)
                SEL_DATA: rd_word = (out_q & dir_q) | (pin_s & ~dir_q);
                SEL_DIR:  rd_word = dir_q;
                SEL_MASK: rd_word = mask_q;
                default:  rd_word = cap_q;
            endcase
            rdata[WIDTH-1:0] = rd_word;
        end
    end

    // R2: direction follows the last write
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_DIR) |=> (dir_q == $past(wdata)));

    // R3: output latch only changes on a data write
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_DATA) |=> $stable(out_q));

    // R6: mask only changes on a mask write
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_MASK) |=> $stable(mask_q));

endmodule

// File: rtl/gpio_edge_port.sv
// Module: top of the GPIO port. Connects the synchroniser, edge capture and
// register file, and forms the interrupt. Assumes a single clock and that
// WIDTH is between 1 and 32.
module gpio_edge_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [WIDTH-1:0]  pin_i,
    output logic [WIDTH-1:0]  pin_o,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);

    localparam int SYNC_STAGES = 2;

    reg_sel_e         sel;
    logic [WIDTH-1:0] pin_s;
    logic [WIDTH-1:0] cap_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] mask_q;
    logic             cap_clr;

    // Register select from the word offset
    assign sel = reg_sel_e'(bus_addr[3:2]);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (pin_s)
    );

    gpio_edge_cap #(.WIDTH(WIDTH)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_s (pin_s),
        .clr   (cap_clr),
        .cap_q (cap_q),
        .rise  (rise)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata[WIDTH-1:0]),
        .pin_s   (pin_s),
        .cap_q   (cap_q),
        .out_q   (pin_o),
        .dir_q   (pin_oe),
        .mask_q  (mask_q),
        .cap_clr (cap_clr),
        .rdata   (bus_rdata)
    );

    // Level interrupt from any enabled captured edge
    assign irq = |(mask_q & cap_q);

    // Bus bits that carry no meaning for this width
    generate
        if (WIDTH < 32) begin : g_upper
            logic unused_bits;
            assign unused_bits = ^{bus_wdata[31:WIDTH], bus_addr[1:0]};

            // R7: upper read bits stay zero
            a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata[31:WIDTH] == '0);
        end else begin : g_full
            logic unused_bits;
            assign unused_bits = ^bus_addr[1:0];
        end
    endgenerate

    // R1: reset leaves all pins as inputs and the capture and mask empty
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && cap_q == '0 && mask_q == '0 && !irq));

    // R6: nothing captured means no interrupt
    a_r6_irq_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q == '0) |-> !irq);

    // R8: reading never disturbs the capture register
    a_r8_read_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && rise == '0) |=> $stable(cap_q));

endmodule

// File: tb/test_gpio_edge_port.sv
// Bench: fixed-seed random bus and pin traffic, plus directed corner cases,
// checked against a cycle-level model built from the requirements.
module test_gpio_edge_port;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   bus_addr;
    logic         bus_rd;
    logic         bus_wr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [W-1:0] pin_i;
    logic [W-1:0] pin_o;
    logic [W-1:0] pin_oe;
    logic         irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Model state
    logic [W-1:0] m_out, m_dir, m_mask, m_cap, m_s1, m_s2, m_prev;

    gpio_edge_port #(.WIDTH(W)) i_gpio_edge_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_i     (pin_i),
        .pin_o     (pin_o),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] exp_read(logic [3:0] a);
        logic [31:0] r;
        r = '0;
        case (a[3:2])
            2'd0: r[W-1:0] = (m_out & m_dir) | (m_s2 & ~m_dir);
            2'd1: r[W-1:0] = m_dir;
            2'd2: r[W-1:0] = m_mask;
            default: r[W-1:0] = m_cap;
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: drive, check comb outputs, clock, update model
    task automatic cycle(bit wr, bit rd, logic [3:0] a, logic [31:0] d, logic [W-1:0] pins);
        logic [W-1:0] rise;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; pin_i = pins;
        #1;
        if (rd) begin
            case (a[3:2])
                2'd0: check("R3 data read", bus_rdata, exp_read(a));
                2'd1: check("R2 dir read", bus_rdata, exp_read(a));
                2'd2: check("R6 mask read", bus_rdata, exp_read(a));
                default: check("R4 capture read", bus_rdata, exp_read(a));
            endcase
            check("R7 upper read bits", {16'd0, bus_rdata[31:W]}, 32'd0);
        end else begin
            check("R8 idle read data", bus_rdata, 32'd0);
        end
        check("R2 pin_oe", 32'(pin_oe), 32'(m_dir));
        check("R3 pin_o", 32'(pin_o), 32'(m_out));
        check("R6 irq", 32'(irq), 32'(|(m_mask & m_cap)));
        rise = m_s2 & ~m_prev;
        @(posedge clk);
        if (wr && a[3:2] == 2'd3) m_cap = rise;
        else m_cap = m_cap | rise;
        if (wr && a[3:2] == 2'd0) m_out  = d[W-1:0];
        if (wr && a[3:2] == 2'd1) m_dir  = d[W-1:0];
        if (wr && a[3:2] == 2'd2) m_mask = d[W-1:0];
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pins;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; pin_i = '0;
        m_out = '0; m_dir = '0; m_mask = '0; m_cap = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports and through reads
        check("R1 pin_oe after reset", 32'(pin_oe), 32'd0);
        check("R1 irq after reset", 32'(irq), 32'd0);
        cycle(0, 1, 4'h4, 0, '0);
        cycle(0, 1, 4'h8, 0, '0);
        cycle(0, 1, 4'hC, 0, '0);
        cycle(0, 1, 4'h0, 0, '0);

        // R7: upper write bits ignored
        cycle(1, 0, 4'h4, 32'hFFFF_A5C3, '0);
        cycle(0, 1, 4'h4, 0, '0);
        check("R7 dir readback masked", bus_rdata, 32'h0000_A5C3);
        cycle(1, 0, 4'h0, 32'h1234_FFFF, '0);
        cycle(0, 1, 4'h0, 0, '0);

        // R3: input bits show synchronised pins after two edges
        pins = 16'h5A5A;
        cycle(0, 0, 4'h0, 0, pins);
        cycle(0, 0, 4'h0, 0, pins);
        cycle(0, 1, 4'h0, 0, pins);
        check("R3 mixed data read", bus_rdata, {16'd0, (16'hFFFF & 16'hA5C3) | (pins & ~16'hA5C3)});

        // R5: clear lands on the same edge as a new rising edge on bit 0
        cycle(1, 0, 4'h8, 32'h0000_0001, pins);
        cycle(1, 0, 4'hC, 0, pins);
        pins = pins | 16'h0001;
        cycle(0, 0, 4'h0, 0, pins);
        cycle(0, 0, 4'h0, 0, pins);
        cycle(1, 0, 4'hC, 32'hDEAD_BEEF, pins);
        cycle(0, 1, 4'hC, 0, pins);
        check("R5 same-cycle edge kept", bus_rdata, 32'h0000_0001);
        check("R6 irq from kept edge", 32'(irq), 32'd1);

        // R4: falling edge sets nothing; R8: reads keep capture
        cycle(1, 0, 4'hC, 0, pins);
        pins = '0;
        repeat (4) cycle(0, 1, 4'hC, 0, pins);
        check("R4 falling edge ignored", bus_rdata, 32'd0);
        pins = 16'h8000;
        repeat (4) cycle(0, 1, 4'hC, 0, pins);
        check("R8 capture kept over reads", bus_rdata, 32'h0000_8000);
        check("R6 masked-off edge no irq", 32'(irq), 32'd0);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] < 4'd3) pins = pins ^ W'($urandom);
            cycle(r[4] & r[5] & r[6], r[7], {r[9:8], r[11:10]}, $urandom, pins);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule